// File: doc/BRIEF.md
# Cycle-Stealing Block Mover

This block copies a run of words between a streaming peripheral and system memory without help from the processor. Software loads a start location and a word total through a small register port, then writes a control word that selects the direction and starts the run. From then on the mover borrows memory one cycle at a time. It uses only cycles in which the processor has left memory idle, which the `mem_busy` input reports, and it never holds memory for longer than one strobe.

Toward the peripheral it uses a valid/accepted pair in each direction. When filling memory, the peripheral offers words on `pi_valid`/`pi_data`, and the mover answers with a one-cycle `pi_ack` after the word has been written. When draining memory, the mover offers words on `po_valid`/`po_data` and holds each one until `po_accept` is seen. The location advances by one and the remaining total drops by one for every word. When the total reaches zero the mover goes back to idle and raises a done status bit.

The controller has seven states. IDLE leaves on a start write with a nonzero total: it goes to FILL_WAIT when the direction bit is 0 and to DRAIN_READ when it is 1. FILL_WAIT goes to FILL_WRITE when `pi_valid` is high, and latches the word on the way. FILL_WRITE goes to FILL_ACK in the first cycle with `mem_busy` low, and writes the word in that cycle. FILL_ACK returns to FILL_WAIT, or to IDLE with done when the total is zero. DRAIN_READ goes to DRAIN_LATCH in the first cycle with `mem_busy` low, and reads in that cycle. DRAIN_LATCH captures `mem_rdata` and goes to DRAIN_OFFER. DRAIN_OFFER waits for `po_accept` and then returns to DRAIN_READ, or to IDLE with done when the total is zero.

Top module: `dma_steal`

## Requirements
- R1: After reset the block is idle. The location, total and status read back as zero, and `mem_rd`, `mem_wr`, `pi_ack` and `po_valid` are low.
- R2: A write with `cfg_sel`=2 and `cfg_wdata` bit 0 set, made while idle with a nonzero total, starts a run. Bit 1 picks the direction: 0 fills memory from the peripheral and 1 drains memory to it. From the next cycle the status reads busy=1 and done=0.
- R3: A start write made while the total is zero sets done from the next cycle. The block stays idle and issues no memory strobe.
- R4: `mem_rd` or `mem_wr` is high only in a cycle where `mem_busy` is low. The two are never high together. Each run issues exactly one strobe per word.
- R5: In fill mode a word seen with `pi_valid` is latched and written with `mem_wr` to the current location. `pi_ack` is then high for exactly one cycle.
- R6: In drain mode a `mem_rd` at the current location is followed one cycle later by the data on `mem_rdata`. That word is offered on `po_data` with `po_valid`, and both are held unchanged until `po_accept` is high.
- R7: Each memory strobe adds one to the location and takes one from the total, starting from the next cycle.
- R8: When the last word's handshake completes, the block returns to idle and done reads 1. The total reads 0 and the location reads start plus word total.
- R9: Register writes (location, total, control) made while busy are ignored.
- R10: Read-back is combinational from `cfg_sel`. Code 0 gives the location, 1 the total, and 2 the status: bit 0 busy, bit 1 direction, bit 2 done. Codes 0 to 2 with the same meanings select the register on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and read-back |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read-back data |
| mem_busy | input | 1 | Processor is using memory this cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory location |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_rd` |
| pi_valid | input | 1 | Peripheral offers a word (fill mode) |
| pi_data | input | DW | Word offered by the peripheral |
| pi_ack | output | 1 | Word taken from the peripheral |
| po_valid | output | 1 | Mover offers a word (drain mode) |
| po_data | output | DW | Word offered to the peripheral |
| po_accept | input | 1 | Peripheral takes the offered word |

## Verification
The bench drives `mem_busy` at random densities up to nearly always busy, so that a mover which strobes through a busy cycle, or stops waiting for idle cycles, leaves wrong memory contents or a wrong strobe count. One-word runs and a zero-total start test the terminal count. An off-by-one there would move one word too many, which corrupts the sentinel word kept just past the block, or would never raise done. Writes to the location, total and control made during a run must leave the run unchanged, so a mover that accepts them ends at the wrong location or in the wrong direction. Random gaps on `po_accept` and `pi_valid` show whether a drained word is dropped or repeated, and whether a filled word is taken twice.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_WAIT,
        ST_FILL_WRITE,
        ST_FILL_ACK,
        ST_DRAIN_READ,
        ST_DRAIN_LATCH,
        ST_DRAIN_OFFER
    } mover_state_t;

    localparam logic [1:0] SEL_LOC  = 2'd0;
    localparam logic [1:0] SEL_LEFT = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_DIR_BIT = 1;

endpackage

// File: rtl/dma_steal_regs.sv
module dma_steal_regs
    import dma_steal_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          busy,
    input  logic          step,
    input  logic          done_set,
    output logic [AW-1:0] loc,
    output logic          left_zero,
    output logic          start_go
);

    logic [CW-1:0] left_q;
    logic          dir_q;
    logic          done_q;
    logic          wr_ok;

    assign wr_ok     = cfg_we && !busy;
    assign start_go  = wr_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_GO_BIT];
    assign left_zero = (left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc    <= '0;
            left_q <= '0;
            dir_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (wr_ok && cfg_sel == SEL_LOC) begin
                loc <= cfg_wdata[AW-1:0];
            end else if (step) begin
                loc <= loc + 1'b1;
            end
            if (wr_ok && cfg_sel == SEL_LEFT) begin
                left_q <= cfg_wdata[CW-1:0];
            end else if (step) begin
                left_q <= left_q - 1'b1;
            end
            if (start_go) begin
                dir_q  <= cfg_wdata[CTRL_DIR_BIT];
                done_q <= left_zero;
            end else if (done_set) begin
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (cfg_sel)
            SEL_LOC:  cfg_rdata = DW'(loc);
            SEL_LEFT: cfg_rdata = DW'(left_q);
            SEL_CTRL: cfg_rdata = DW'({done_q, dir_q, busy});
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_steal_fsm.sv
module dma_steal_fsm
    import dma_steal_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_go,
    input  logic          start_dir,
    input  logic          left_zero,
    input  logic          mem_busy,
    input  logic [DW-1:0] mem_rdata,
    input  logic          pi_valid,
    input  logic [DW-1:0] pi_data,
    input  logic          po_accept,
    output logic          busy,
    output logic          step,
    output logic          done_set,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          pi_ack,
    output logic          po_valid,
    output logic [DW-1:0] word
);

    mover_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (state == ST_FILL_WAIT && pi_valid) begin
            word <= pi_data;
        end else if (state == ST_DRAIN_LATCH) begin
            word <= mem_rdata;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:
                if (start_go && !left_zero)
                    state_nx = start_dir ? ST_DRAIN_READ : ST_FILL_WAIT;
            ST_FILL_WAIT:
                if (pi_valid) state_nx = ST_FILL_WRITE;
            ST_FILL_WRITE:
                if (!mem_busy) state_nx = ST_FILL_ACK;
            ST_FILL_ACK:
                state_nx = left_zero ? ST_IDLE : ST_FILL_WAIT;
            ST_DRAIN_READ:
                if (!mem_busy) state_nx = ST_DRAIN_LATCH;
            ST_DRAIN_LATCH:
                state_nx = ST_DRAIN_OFFER;
            ST_DRAIN_OFFER:
                if (po_accept) state_nx = left_zero ? ST_IDLE : ST_DRAIN_READ;
            default:
                state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        mem_wr   = (state == ST_FILL_WRITE) && !mem_busy;
        mem_rd   = (state == ST_DRAIN_READ) && !mem_busy;
        pi_ack   = (state == ST_FILL_ACK);
        po_valid = (state == ST_DRAIN_OFFER);
        step     = mem_wr || mem_rd;
        done_set = left_zero &&
                   ((state == ST_FILL_ACK) || (state == ST_DRAIN_OFFER && po_accept));
    end

endmodule

// File: rtl/dma_steal.sv
module dma_steal #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          mem_busy,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          pi_valid,
    input  logic [DW-1:0] pi_data,
    output logic          pi_ack,
    output logic          po_valid,
    output logic [DW-1:0] po_data,
    input  logic          po_accept
);

    logic          busy;
    logic          step;
    logic          done_set;
    logic          left_zero;
    logic          start_go;
    logic [DW-1:0] word;

    dma_steal_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .step      (step),
        .done_set  (done_set),
        .loc       (mem_addr),
        .left_zero (left_zero),
        .start_go  (start_go)
    );

    dma_steal_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_go  (start_go),
        .start_dir (cfg_wdata[1]),
        .left_zero (left_zero),
        .mem_busy  (mem_busy),
        .mem_rdata (mem_rdata),
        .pi_valid  (pi_valid),
        .pi_data   (pi_data),
        .po_accept (po_accept),
        .busy      (busy),
        .step      (step),
        .done_set  (done_set),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .pi_ack    (pi_ack),
        .po_valid  (po_valid),
        .word      (word)
    );

    assign mem_wdata = word;
    assign po_data   = word;

endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_busy,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          pi_ack,
    input logic          po_valid,
    input logic          po_accept,
    input logic [DW-1:0] po_data
);

    AST_STROBE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !mem_busy);                                    // R4

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));                                                 // R4

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pi_ack |=> !pi_ack);                                                  // R5

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (po_valid && !po_accept) |=> (po_valid && $stable(po_data)));         // R6

    AST_LOC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> (mem_addr == $past(mem_addr) + 1'b1));         // R7

    AST_NO_STROBE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        po_valid |-> !(mem_rd || mem_wr));                                    // R6

endmodule

bind dma_steal dma_steal_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_busy  (mem_busy),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .pi_ack    (pi_ack),
    .po_valid  (po_valid),
    .po_accept (po_accept),
    .po_data   (po_data)
);

// File: tb/tb_dma_steal.sv
`timescale 1ns/1ps
module tb_dma_steal;

    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          mem_busy = 1'b0;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          pi_valid = 1'b0;
    logic [DW-1:0] pi_data = '0;
    logic          pi_ack;
    logic          po_valid;
    logic [DW-1:0] po_data;
    logic          po_accept = 1'b0;

    dma_steal #(.AW(AW), .DW(DW), .CW(16)) dut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int busy_pct = 0;
    int mode = 0;                 // 0 none, 1 fill source, 2 drain sink
    int strobes = 0, bad_strobes = 0;
    logic [DW-1:0] mem [0:255];
    logic [DW-1:0] src [0:15];
    logic [DW-1:0] got [0:15];
    int sidx = 0, snum = 0, gidx = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] status_word(input bit done, input bit dir, input bit bsy);
        return DW'({done, dir, bsy});
    endfunction

    // memory model: write at edge, read data one cycle after strobe
    always @(posedge clk) begin
        cyc++;
        if (mem_rd || mem_wr) begin
            strobes++;
            if (mem_busy) bad_strobes++;
        end
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // stimulus on the falling edge
    always @(negedge clk) begin
        mem_busy = ($urandom % 100) < busy_pct;
        if (pi_ack) sidx++;
        pi_valid = (mode == 1) && (sidx < snum) && (($urandom % 4) != 0);
        pi_data  = src[sidx[3:0]];
        begin
            bit a;
            a = (mode == 2) && (($urandom % 3) != 0);
            if (po_valid && a) begin
                got[gidx[3:0]] = po_data;
                gidx++;
            end
            po_accept = a;
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [DW-1:0] v);
        cfg_sel = sel;
        #0.5;
        v = cfg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [DW-1:0] v;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rd(2'd2, v);
            if (v[2]) return;
        end
        chk(req, 32'(v[2]), 32'd1);
    endtask

    // one run; returns after done, checks everything
    task automatic xfer(input bit d, input int a, input int n, input int bpct, input bit poke);
        logic [DW-1:0] v;
        logic [DW-1:0] sentinel;
        int s0, b0;
        busy_pct = bpct;
        sentinel = DW'($urandom);
        mem[(a + n) % 256] = sentinel;
        if (!d) begin
            for (int i = 0; i < n; i++) src[i] = DW'($urandom);
            sidx = 0; snum = n; mode = 1;
        end else begin
            for (int i = 0; i < n; i++) mem[a + i] = DW'($urandom);
            gidx = 0; mode = 2;
        end
        s0 = strobes; b0 = bad_strobes;
        cfg_write(2'd0, DW'(a));
        cfg_write(2'd1, DW'(n));
        cfg_write(2'd2, DW'({d, 1'b1}));
        rd(2'd2, v);
        chk("R2 started, busy set and done cleared", 32'(v), 32'(status_word(1'b0, d, 1'b1)));
        if (poke) begin
            cfg_write(2'd0, DW'(16'h0055));
            cfg_write(2'd1, DW'(16'd9));
            cfg_write(2'd2, DW'({~d, 1'b1}));
        end
        wait_done("R8 done raised");
        mode = 0;
        @(negedge clk);
        rd(2'd1, v);
        chk("R8 total reads zero", 32'(v), 32'd0);
        rd(2'd0, v);
        chk("R7 location advanced by total", 32'(v), 32'((a + n) & 16'hFFFF));
        rd(2'd2, v);
        chk(poke ? "R9 direction kept despite write" : "R8 idle with done",
            32'(v), 32'(status_word(1'b1, d, 1'b0)));
        chk("R4 one strobe per word", 32'(strobes - s0), 32'(n));
        chk("R4 no strobe in busy cycle", 32'(bad_strobes - b0), 32'd0);
        chk("R8 word past block untouched", 32'(mem[(a + n) % 256]), 32'(sentinel));
        if (!d) begin
            for (int i = 0; i < n; i++)
                chk("R5 filled word in memory", 32'(mem[a + i]), 32'(src[i]));
        end else begin
            chk("R6 drained word count", 32'(gidx), 32'(n));
            for (int i = 0; i < n; i++)
                chk("R6 drained word matches memory", 32'(got[i]), 32'(mem[a + i]));
        end
    endtask

    initial begin
        logic [DW-1:0] v;
        int s0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 location reset", 32'(v), 32'd0);
        rd(2'd1, v); chk("R1 total reset", 32'(v), 32'd0);
        rd(2'd2, v); chk("R1 status reset", 32'(v), 32'd0);
        chk("R1 strobes low", 32'({mem_rd, mem_wr, pi_ack, po_valid}), 32'd0);

        // R3 zero total start
        s0 = strobes;
        cfg_write(2'd2, DW'(2'b01));
        rd(2'd2, v);
        chk("R3 zero total sets done at once", 32'(v), 32'(status_word(1'b1, 1'b0, 1'b0)));
        repeat (5) @(negedge clk);
        chk("R3 no memory access", 32'(strobes - s0), 32'd0);

        // R10 register write and read-back codes
        cfg_write(2'd0, DW'(16'h00A5));
        cfg_write(2'd1, DW'(16'h0003));
        rd(2'd0, v); chk("R10 location read-back", 32'(v), 32'h00A5);
        rd(2'd1, v); chk("R10 total read-back", 32'(v), 32'h0003);

        // directed corners
        xfer(1'b0, 10, 1, 0, 1'b0);
        xfer(1'b1, 10, 1, 0, 1'b0);
        xfer(1'b0, 40, 5, 90, 1'b0);
        xfer(1'b1, 40, 5, 90, 1'b0);
        xfer(1'b0, 60, 6, 50, 1'b1);    // R9 writes during a fill run
        xfer(1'b1, 80, 6, 50, 1'b1);    // R9 writes during a drain run

        // random runs
        for (int k = 0; k < 12; k++)
            xfer(1'($urandom), 100 + int'($urandom % 100), 1 + int'($urandom % 12),
                 int'($urandom % 95), 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule